// File: doc/BRIEF.md
# Thresholded Multi-Occurrence Event Counter

This block is a performance-monitoring counter whose input is a per-cycle occurrence count from 0 to 7, not a single event pulse. Several instances of one event can retire in the same cycle. The counter either adds the full count or, when a non-zero threshold is programmed, counts cycles in which the occurrences exceed that threshold. A threshold of n turns the counter into a "cycles with more than n events" counter. The valid threshold for an event runs from zero up to one less than that event's per-cycle maximum. For example, an event with at most six occurrences per cycle takes thresholds 0 to 5.

Counting is gated by three filters:
- a four-bit privilege mask, which enables counting at the privilege levels whose bits are set;
- an instruction-set select, which picks mode A, mode B or both;
- an external qualifier, such as an address-range or opcode match, which a configuration override can make the counter ignore.

The counter is 47 bits wide and wraps. On a wrap it produces a one-cycle overflow pulse. A software write loads a new value. Event selection and interrupt delivery belong to the surrounding logic.

Top module: `thresh_event_counter`

## Requirements
- R1: While `rstN` is low, `countValue` is 0 and `overflowPulse` is 0.
- R2: When `cfgThreshold` is 0 and the cycle is eligible, the counter adds `occCount` in full.
- R3: When `cfgThreshold` is a non-zero n and the cycle is eligible, the counter adds exactly 1 when `occCount` > n, and adds 0 otherwise.
- R4: `cfgIsetSel` selects the instruction-set mode in which counting happens. `isetModeB` is 0 in mode A and 1 in mode B. The select values mean:
  - 0: count in both modes;
  - 1: count only in mode A;
  - 2: count only in mode B;
  - 3: count in both modes.
- R5: A cycle counts only if bit `privLevel` of `cfgPrivMask` is 1. Bit i enables level i.
- R6: A cycle counts only if `qualMatch` is 1 or `cfgQualOverride` is 1. When the override is set, the qualifier has no effect.
- R7: The counter is 47 bits wide and wraps modulo 2^47. An increment that wraps makes `overflowPulse` high for exactly the one cycle in which the wrapped value is first shown.
- R8: When `wrEn` is 1, `countValue` becomes `wrData`, even if the same cycle is eligible to increment. A write never raises `overflowPulse`.
- R9: Each result appears at the first rising clock edge after the inputs that cause it. This holds for both `countValue` and `overflowPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| occCount | input | 3 | Event occurrences in this cycle |
| privLevel | input | 2 | Current privilege level (0 to 3) |
| isetModeB | input | 1 | Current instruction-set mode: 0 = mode A, 1 = mode B |
| qualMatch | input | 1 | External qualifier (range or opcode match) |
| cfgThreshold | input | 3 | Per-cycle occurrence threshold |
| cfgIsetSel | input | 2 | Instruction-set select |
| cfgPrivMask | input | 4 | Privilege-level enable mask |
| cfgQualOverride | input | 1 | Ignore the external qualifier |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 47 | Value to load |
| countValue | output | 47 | Current counter value |
| overflowPulse | output | 1 | One-cycle pulse when the counter wraps |

## Verification
Both the counter value and the overflow pulse are registered once. Stimulus that is applied before a rising edge is therefore visible right after that edge: the new count, the wrap and its pulse all appear there. The bench drives every input on the falling edge and waits for one rising edge. It then samples both outputs on the following falling edge and compares them with its own arithmetic model. It also checks that the pulse drops again one cycle later.

// File: rtl/thresh_counter_pkg.sv
package thresh_counter_pkg;
  localparam int OCC_W = 3;

  typedef struct packed {
    logic             load;
    logic             incEn;
    logic [OCC_W-1:0] incAmt;
  } ctr_strobes_t;
endpackage

// File: rtl/thresh_counter_ctrl.sv
module thresh_counter_ctrl
  import thresh_counter_pkg::*;
(
  input  logic [OCC_W-1:0] occCount,
  input  logic [1:0]       privLevel,
  input  logic             isetModeB,
  input  logic             qualMatch,
  input  logic [OCC_W-1:0] cfgThreshold,
  input  logic [1:0]       cfgIsetSel,
  input  logic [3:0]       cfgPrivMask,
  input  logic             cfgQualOverride,
  input  logic             wrEn,
  output ctr_strobes_t     strobes
);
  logic privOk;
  logic isetOk;
  logic qualOk;
  logic eligible;
  logic [OCC_W-1:0] amount;

  assign privOk = cfgPrivMask[privLevel];
  assign qualOk = qualMatch | cfgQualOverride;

  always_comb begin
    unique case (cfgIsetSel)
      2'd1:    isetOk = ~isetModeB;
      2'd2:    isetOk = isetModeB;
      default: isetOk = 1'b1;
    endcase
  end

  assign eligible = privOk & isetOk & qualOk;

  always_comb begin
    if (cfgThreshold == '0)
      amount = occCount;
    else if (occCount > cfgThreshold)
      amount = OCC_W'(1);
    else
      amount = '0;
  end

  always_comb begin
    strobes.load   = wrEn;
    strobes.incEn  = eligible & ~wrEn & (amount != '0);
    strobes.incAmt = amount;
  end
endmodule

// File: rtl/thresh_counter_dp.sv
module thresh_counter_dp
  import thresh_counter_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctr_strobes_t     strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countValue,
  output logic             overflowPulse
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, countValue} + {{(SUM_W-OCC_W){1'b0}}, strobes.incAmt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countValue    <= '0;
      overflowPulse <= 1'b0;
    end else if (strobes.load) begin
      countValue    <= wrData;
      overflowPulse <= 1'b0;
    end else if (strobes.incEn) begin
      countValue    <= sum[CNT_W-1:0];
      overflowPulse <= sum[CNT_W];
    end else begin
      overflowPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/thresh_event_counter.sv
module thresh_event_counter
  import thresh_counter_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       occCount,
  input  logic [1:0]       privLevel,
  input  logic             isetModeB,
  input  logic             qualMatch,
  input  logic [2:0]       cfgThreshold,
  input  logic [1:0]       cfgIsetSel,
  input  logic [3:0]       cfgPrivMask,
  input  logic             cfgQualOverride,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countValue,
  output logic             overflowPulse
);
  ctr_strobes_t strobes;

  thresh_counter_ctrl u_ctrl (
    .occCount        (occCount),
    .privLevel       (privLevel),
    .isetModeB       (isetModeB),
    .qualMatch       (qualMatch),
    .cfgThreshold    (cfgThreshold),
    .cfgIsetSel      (cfgIsetSel),
    .cfgPrivMask     (cfgPrivMask),
    .cfgQualOverride (cfgQualOverride),
    .wrEn            (wrEn),
    .strobes         (strobes)
  );

  thresh_counter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (wrData),
    .countValue    (countValue),
    .overflowPulse (overflowPulse)
  );
endmodule

// File: rtl/thresh_event_counter_chk.sv
module thresh_event_counter_chk #(
  parameter int CNT_W = 47
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       occCount,
  input logic [1:0]       privLevel,
  input logic             isetModeB,
  input logic             qualMatch,
  input logic [2:0]       cfgThreshold,
  input logic [1:0]       cfgIsetSel,
  input logic [3:0]       cfgPrivMask,
  input logic             cfgQualOverride,
  input logic             wrEn,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] countValue,
  input logic             overflowPulse
);
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (countValue == $past(wrData)) && !overflowPulse); // R8

  AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgPrivMask[privLevel] && !wrEn) |=> $stable(countValue)); // R5

  AST_ISET_MODE_B_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIsetSel == 2'd2 && !isetModeB && !wrEn) |=> $stable(countValue)); // R4

  AST_QUAL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!qualMatch && !cfgQualOverride && !wrEn) |=> $stable(countValue)); // R6

  AST_THRESH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgThreshold != 3'd0 && !wrEn) |=> ((countValue - $past(countValue)) <= CNT_W'(1))); // R3

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |=> !overflowPulse); // R7

  AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> (countValue < $past(countValue))); // R7
endmodule

bind thresh_event_counter thresh_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .occCount        (occCount),
  .privLevel       (privLevel),
  .isetModeB       (isetModeB),
  .qualMatch       (qualMatch),
  .cfgThreshold    (cfgThreshold),
  .cfgIsetSel      (cfgIsetSel),
  .cfgPrivMask     (cfgPrivMask),
  .cfgQualOverride (cfgQualOverride),
  .wrEn            (wrEn),
  .wrData          (wrData),
  .countValue      (countValue),
  .overflowPulse   (overflowPulse)
);

// File: tb/sim_thresh_event_counter.sv
`timescale 1ns/1ps
module sim_thresh_event_counter;
  localparam int CNT_W = 47;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] occCount = '0;
  logic [1:0] privLevel = '0;
  logic isetModeB = 1'b0;
  logic qualMatch = 1'b0;
  logic [2:0] cfgThreshold = '0;
  logic [1:0] cfgIsetSel = '0;
  logic [3:0] cfgPrivMask = '0;
  logic cfgQualOverride = 1'b0;
  logic wrEn = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] countValue;
  logic overflowPulse;

  int errors = 0;
  int checks = 0;
  logic [CNT_W-1:0] model = '0;
  logic modelOvf = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  thresh_event_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .occCount(occCount), .privLevel(privLevel),
    .isetModeB(isetModeB), .qualMatch(qualMatch), .cfgThreshold(cfgThreshold),
    .cfgIsetSel(cfgIsetSel), .cfgPrivMask(cfgPrivMask),
    .cfgQualOverride(cfgQualOverride), .wrEn(wrEn), .wrData(wrData),
    .countValue(countValue), .overflowPulse(overflowPulse)
  );

  task automatic check(input string tag, input logic [CNT_W-1:0] expV, input logic expO);
    checks++;
    if (countValue !== expV || overflowPulse !== expO) begin
      errors++;
      $display("FAIL %s: count=%0h ovf=%0b expected count=%0h ovf=%0b",
               tag, countValue, overflowPulse, expV, expO);
    end
  endtask

  // Inputs are already set at a falling edge; apply one rising edge,
  // then sample at the next falling edge (R9: one-edge latency).
  task automatic step(input string tag);
    logic elig;
    logic [CNT_W:0] s;
    int amt;
    elig = cfgPrivMask[privLevel] && (qualMatch || cfgQualOverride) &&
           ((cfgIsetSel == 2'd1) ? !isetModeB :
            (cfgIsetSel == 2'd2) ? isetModeB : 1'b1);
    if (cfgThreshold == 0) amt = int'(occCount);
    else amt = (occCount > cfgThreshold) ? 1 : 0;
    if (wrEn) begin
      model = wrData; modelOvf = 1'b0;
    end else if (elig) begin
      s = {1'b0, model} + (CNT_W+1)'(amt);
      model = s[CNT_W-1:0]; modelOvf = s[CNT_W];
    end else modelOvf = 1'b0;
    @(posedge clk); @(negedge clk);
    check(tag, model, modelOvf);
  endtask

  task automatic load(input logic [CNT_W-1:0] v);
    wrEn = 1'b1; wrData = v;
    step("R8 load");
    wrEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rstN = 1'b1;
    cfgPrivMask = 4'hF; qualMatch = 1'b1;

    // R2 / R3: full sweep of threshold and occurrence count
    for (int t = 0; t < 7; t++) begin
      for (int o = 0; o < 8; o++) begin
        cfgThreshold = 3'(t); occCount = 3'(o);
        step((t == 0) ? "R2 full add" : "R3 threshold");
      end
    end
    cfgThreshold = '0;

    // R5: every privilege level against every mask
    occCount = 3'd3;
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 4; p++) begin
        cfgPrivMask = 4'(m); privLevel = 2'(p);
        step("R5 priv mask");
      end
    end
    cfgPrivMask = 4'hF;

    // R4: every select against both modes
    for (int sel = 0; sel < 4; sel++) begin
      for (int md = 0; md < 2; md++) begin
        cfgIsetSel = 2'(sel); isetModeB = md[0];
        step("R4 iset select");
      end
    end
    cfgIsetSel = '0;

    // R6: qualifier and override
    for (int q = 0; q < 2; q++) begin
      for (int ov = 0; ov < 2; ov++) begin
        qualMatch = q[0]; cfgQualOverride = ov[0];
        step("R6 qualifier");
      end
    end
    qualMatch = 1'b1; cfgQualOverride = 1'b0;

    // R8: write beats an eligible increment
    occCount = 3'd7;
    load(47'h123456789AB);
    step("R8 after load");

    // R7: wrap with full add, then pulse drops
    load({CNT_W{1'b1}} - 47'd2);
    occCount = 3'd5;
    step("R7 wrap");
    occCount = 3'd0;
    step("R7 pulse drops");

    // R7: wrap with threshold step of one
    load({CNT_W{1'b1}});
    cfgThreshold = 3'd2; occCount = 3'd6;
    step("R7 thresh wrap");
    occCount = 3'd2;
    step("R7 pulse drops");

    // R8: write at max with increment pending, no pulse
    cfgThreshold = 3'd0; occCount = 3'd7;
    load({CNT_W{1'b1}});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule